// File: doc/BRIEF.md
# Two-Dimensional 8x8 Forward DCT Engine

This block turns an 8x8 tile of signed 16-bit samples into 64 signed 16-bit frequency coefficients, using a fixed integer schedule that is bit-exact. The tile arrives as eight row beats of eight samples under a valid/ready handshake. Each sample is multiplied by four. Every column then goes through an 8-point one-dimensional transform, and every row of that intermediate result goes through the same transform. Each result is halved toward zero, and the coefficients leave as eight row beats under a second valid/ready handshake.

A single 8x8 register array holds the tile. The first pass reads a column and writes its result back into the same column. The second pass reads rows, so the transpose between the passes comes from the addressing alone. One combinational 1D core is shared by both passes. Only one tile is in flight at a time: the input side closes after the eighth row and opens again once the eighth output row has been taken.

Top module: `fdct8x8_fwd`

## Requirements
- R1: A synchronous active-high `rst` puts the engine into its loading state with no rows held. After reset `in_ready` is 1 and `out_valid` and `out_last` are 0, and a partly loaded tile is dropped.
- R2: Before any transform, every input sample is shifted left by two bits and kept to 16 bits with wraparound (0x2000 becomes -32768).
- R3: The first pass transforms along the row index of the input (one column at a time). The second pass transforms along the column index of that result. Output row k, lane m, is the coefficient with vertical frequency k and horizontal frequency m. Lane m of a row bus occupies bits [16m+15:16m].
- R4: Each 1D pass follows this arithmetic: 16-bit wrapped butterflies; products with the 14-fraction-bit constants 16069, 15137, 13623, 11585, 9102, 6270, 3196; a rounding step of adding 8192 and arithmetically shifting right by 14; and truncation of that result to 16 bits.
- R5: Each final coefficient is the 16-bit second-pass value n divided by two with rounding toward zero, computed as (n - (n>>>15))>>>1 in 17 bits, so -32768 gives -16384 and -3 gives -1.
- R6: Sums and differences between passes wrap modulo 2^16 and do not saturate, including for tiles of full-scale values.
- R7: Exactly eight input beats are taken per tile. After the eighth, `in_ready` stays 0 until the eighth output row is accepted, and it is 1 again on the next cycle. `in_ready` and `out_valid` are never both 1.
- R8: While `out_valid` is 1 and `out_ready` is 0, the next cycle still has `out_valid` high, with `out_row` and `out_last` unchanged.
- R9: `out_valid` first rises on the eighth rising clock edge after the edge that accepts the eighth input row.
- R10: Output rows leave in order 0 to 7, and `out_last` is 1 on row 7 only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An input row is offered |
| in_ready | output | 1 | The engine takes an input row |
| in_row | input | 128 | Eight signed 16-bit samples, lane j at bits [16j+15:16j] |
| out_valid | output | 1 | An output row is offered |
| out_ready | input | 1 | Downstream takes the output row |
| out_row | output | 128 | Eight signed 16-bit coefficients, lane m at bits [16m+15:16m] |
| out_last | output | 1 | Marks output row 7 of the tile |

## Verification
The bench sweeps a single impulse over all 64 positions, which exposes swapped passes or a missing transpose: such a design puts energy at the mirrored frequency. Tiles of 0x2000 and of full-scale values test the wrap in the pre-scale and in the butterflies, where a saturating design would produce different coefficients. Small, mostly odd, negative tiles separate truncation toward zero from floor division, which would give -2 where -1 is expected. Random output stalls and gaps in the input show whether rows are dropped or repeated, and an abort in the middle of a tile shows whether leftover rows remain after reset.

// File: rtl/fdct8_pkg.sv
package fdct8_pkg;
  localparam int N  = 8;   // points per 1D transform
  localparam int SW = 16;  // sample / coefficient width
  localparam int CB = 14;  // fraction bits of the cosine constants
  localparam int AW = 34;  // product accumulator width

  // cosine constants, 14 fraction bits
  localparam int K4  = 16069;
  localparam int K8  = 15137;
  localparam int K12 = 13623;
  localparam int K16 = 11585;
  localparam int K20 = 9102;
  localparam int K24 = 6270;
  localparam int K28 = 3196;

  typedef logic signed [SW-1:0] smp_t;
  typedef logic signed [AW-1:0] acc_t;

  // x4 pre-scale with wraparound
  function automatic smp_t pre4(input smp_t x);
    return {x[SW-3:0], 2'b00};
  endfunction

  // signed sample times constant, full precision
  function automatic acc_t cmul(input smp_t x, input int c);
    acc_t xe;
    acc_t ce;
    xe = AW'(x);
    ce = AW'(c);
    return xe * ce;
  endfunction

  // round half up, drop CB fraction bits, keep SW bits
  function automatic smp_t rnd_narrow(input acc_t a);
    acc_t s;
    s = a + (acc_t'(1) <<< (CB - 1));
    return s[CB+SW-1:CB];
  endfunction

  // divide by two, rounding toward zero, 17-bit intermediate
  function automatic smp_t halve(input smp_t n);
    logic signed [SW:0] d;
    d = {n[SW-1], n} - {(SW+1){n[SW-1]}};
    return d[SW:1];
  endfunction
endpackage

// File: rtl/fdct8_core.sv
module fdct8_core
  import fdct8_pkg::*;
(
  input  smp_t d [N],
  output smp_t q [N]
);
  smp_t s [N];
  smp_t e0, e1, e2, e3;
  smp_t od_d, od_s, p, r;
  smp_t f0, f1, f2, f3;

  always_comb begin
    // butterfly: sums into the low half, differences into the high half
    for (int i = 0; i < N/2; i++) begin
      s[i]     = d[i] + d[N-1-i];
      s[N-1-i] = d[i] - d[N-1-i];
    end
    // even half
    e0 = s[0] + s[3];
    e1 = s[1] + s[2];
    e2 = s[1] - s[2];
    e3 = s[0] - s[3];
    q[0] = rnd_narrow(cmul(e0, K16) + cmul(e1, K16));
    q[4] = rnd_narrow(cmul(e0, K16) - cmul(e1, K16));
    q[2] = rnd_narrow(cmul(e2, K24) + cmul(e3, K8));
    q[6] = rnd_narrow(cmul(e3, K24) - cmul(e2, K8));
    // odd half: wrapped rotation by pi/4 first
    od_d = s[6] - s[5];
    od_s = s[6] + s[5];
    p  = rnd_narrow(cmul(od_d, K16));
    r  = rnd_narrow(cmul(od_s, K16));
    f0 = s[4] + p;
    f1 = s[4] - p;
    f2 = s[7] - r;
    f3 = s[7] + r;
    q[1] = rnd_narrow(cmul(f3, K4)  + cmul(f0, K28));
    q[5] = rnd_narrow(cmul(f2, K20) + cmul(f1, K12));
    q[3] = rnd_narrow(cmul(f2, K12) - cmul(f1, K20));
    q[7] = rnd_narrow(cmul(f3, K28) - cmul(f0, K4));
  end
endmodule

// File: rtl/fdct8_tbuf.sv
module fdct8_tbuf
  import fdct8_pkg::*;
#(
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          ld_en,
  input  logic [IW-1:0] ld_idx,
  input  smp_t          ld_data [N],
  input  logic          cw_en,
  input  logic [IW-1:0] cw_idx,
  input  smp_t          cw_data [N],
  input  logic [IW-1:0] rd_idx,
  output smp_t          col_q [N],
  output smp_t          row_q [N]
);
  smp_t mem [N][N];

  always_ff @(posedge clk) begin
    if (ld_en) begin
      for (int c = 0; c < N; c++) mem[ld_idx][c] <= ld_data[c];
    end else if (cw_en) begin
      for (int rr = 0; rr < N; rr++) mem[rr][cw_idx] <= cw_data[rr];
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      col_q[i] = mem[i][rd_idx];
      row_q[i] = mem[rd_idx][i];
    end
  end

  // R7
  one_writer_chk: assert property (@(posedge clk) !(ld_en && cw_en));
endmodule

// File: rtl/fdct8_seq.sv
module fdct8_seq #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          out_ready,
  output logic          in_ready,
  output logic          out_valid,
  output logic          out_last,
  output logic          ld_en,
  output logic          cw_en,
  output logic          use_col,
  output logic [IW-1:0] idx
);
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  typedef enum logic [1:0] {ST_LOAD, ST_COL, ST_EMIT} st_t;
  st_t           st;
  logic [IW-1:0] cnt;

  // named events
  logic in_fire, out_fire, tile_loaded, tile_sent, col_done;
  assign in_fire     = in_valid && (st == ST_LOAD);
  assign out_fire    = out_ready && (st == ST_EMIT);
  assign tile_loaded = in_fire && (cnt == LAST);
  assign col_done    = (st == ST_COL) && (cnt == LAST);
  assign tile_sent   = out_fire && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= ST_LOAD;
      cnt <= '0;
    end else begin
      unique case (st)
        ST_LOAD: if (in_fire)  cnt <= cnt + 1'b1;
        ST_COL:                cnt <= cnt + 1'b1;
        ST_EMIT: if (out_fire) cnt <= cnt + 1'b1;
        default:               cnt <= '0;
      endcase
      if (tile_loaded)    st <= ST_COL;
      else if (col_done)  st <= ST_EMIT;
      else if (tile_sent) st <= ST_LOAD;
    end
  end

  assign in_ready  = (st == ST_LOAD);
  assign out_valid = (st == ST_EMIT);
  assign out_last  = out_valid && (cnt == LAST);
  assign ld_en     = in_fire;
  assign cw_en     = (st == ST_COL);
  assign use_col   = (st == ST_COL);
  assign idx       = cnt;

  // R7
  ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
    tile_loaded |=> !in_ready);
  // R7
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(in_ready && out_valid));
  // R7
  reopen_chk: assert property (@(posedge clk) disable iff (rst)
    (out_fire && out_last) |=> (in_ready && !out_valid));
  // R10
  last_valid_chk: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);
endmodule

// File: rtl/fdct8x8_fwd.sv
module fdct8x8_fwd
  import fdct8_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [N*SW-1:0] in_row,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [N*SW-1:0] out_row,
  output logic            out_last
);
  localparam int IW = $clog2(N);

  logic          ld_en, cw_en, use_col;
  logic [IW-1:0] idx;
  smp_t          ld_vec  [N];
  smp_t          col_q   [N];
  smp_t          row_q   [N];
  smp_t          core_in [N];
  smp_t          core_q  [N];

  fdct8_seq #(.N(N), .IW(IW)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_last  (out_last),
    .ld_en     (ld_en),
    .cw_en     (cw_en),
    .use_col   (use_col),
    .idx       (idx)
  );

  fdct8_tbuf #(.IW(IW)) u_buf (
    .clk     (clk),
    .ld_en   (ld_en),
    .ld_idx  (idx),
    .ld_data (ld_vec),
    .cw_en   (cw_en),
    .cw_idx  (idx),
    .cw_data (core_q),
    .rd_idx  (idx),
    .col_q   (col_q),
    .row_q   (row_q)
  );

  fdct8_core u_core (
    .d (core_in),
    .q (core_q)
  );

  for (genvar j = 0; j < N; j++) begin : g_lane
    assign ld_vec[j]             = pre4(in_row[j*SW +: SW]);
    assign core_in[j]            = use_col ? col_q[j] : row_q[j];
    assign out_row[j*SW +: SW]   = halve(core_q[j]);
  end

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_row) && $stable(out_last)));
  // R9
  first_out_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> ($past(cw_en) && $past(idx) == IW'(N - 1)));
endmodule

// File: tb/tb_fdct8x8_fwd.sv
module tb_fdct8x8_fwd;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 100000;

  logic         clk = 0;
  logic         rst;
  logic         in_valid, in_ready, out_valid, out_ready, out_last;
  logic [127:0] in_row, out_row;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int blk   [8][8];
  int exp_c [8][8];

  always #(CLK_PERIOD/2) clk = ~clk;

  fdct8x8_fwd dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_row(in_row), .out_valid(out_valid), .out_ready(out_ready),
    .out_row(out_row), .out_last(out_last)
  );

  task automatic check(input bit ok, input string tag, input int got, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", tag, got, expv);
    end
  endtask

  function automatic int w16(input int v);
    return int'(shortint'(v));
  endfunction

  function automatic int rnd(input longint t);
    return w16(int'((t + 64'sd8192) >>> 14));
  endfunction

  // bench model of the 8-point pass
  function automatic void ref1d(input int a [8], output int o [8]);
    int s [8];
    int x0, x1, x2, x3, p, q, u0, u1, u2, u3;
    for (int i = 0; i < 4; i++) begin
      s[i]   = w16(a[i] + a[7-i]);
      s[7-i] = w16(a[i] - a[7-i]);
    end
    x0 = w16(s[0] + s[3]); x1 = w16(s[1] + s[2]);
    x2 = w16(s[1] - s[2]); x3 = w16(s[0] - s[3]);
    o[0] = rnd(longint'(x0 + x1) * 11585);
    o[4] = rnd(longint'(x0 - x1) * 11585);
    o[2] = rnd(longint'(x2) * 6270 + longint'(x3) * 15137);
    o[6] = rnd(longint'(x3) * 6270 - longint'(x2) * 15137);
    p = rnd(longint'(w16(s[6] - s[5])) * 11585);
    q = rnd(longint'(w16(s[6] + s[5])) * 11585);
    u0 = w16(s[4] + p); u1 = w16(s[4] - p);
    u2 = w16(s[7] - q); u3 = w16(s[7] + q);
    o[1] = rnd(longint'(u3) * 16069 + longint'(u0) * 3196);
    o[5] = rnd(longint'(u2) * 9102 + longint'(u1) * 13623);
    o[3] = rnd(longint'(u2) * 13623 - longint'(u1) * 9102);
    o[7] = rnd(longint'(u3) * 3196 - longint'(u0) * 16069);
  endfunction

  task automatic build_expect();
    int y [8][8];
    int a [8];
    int o [8];
    for (int j = 0; j < 8; j++) begin
      for (int i = 0; i < 8; i++) a[i] = w16(blk[i][j] * 4);
      ref1d(a, o);
      for (int k = 0; k < 8; k++) y[k][j] = o[k];
    end
    for (int k = 0; k < 8; k++) begin
      for (int m = 0; m < 8; m++) a[m] = y[k][m];
      ref1d(a, o);
      for (int m = 0; m < 8; m++) exp_c[k][m] = o[m] / 2;  // truncates toward zero
    end
  endtask

  task automatic run_block(input string tag);
    int r, lows, k;
    bit rdy;
    logic [127:0] held;
    logic held_last;
    build_expect();
    r = 0;
    while (r < 8) begin
      bit ok;
      @(negedge clk);
      in_valid = ($urandom_range(3, 0) != 0);
      for (int j = 0; j < 8; j++) in_row[j*16 +: 16] = 16'(blk[r][j]);
      ok = in_valid && in_ready;
      @(posedge clk);
      if (ok) r++;
    end
    @(negedge clk);
    in_valid = 0;
    lows = 0;
    while (!out_valid && lows < 40) begin
      lows++;
      @(negedge clk);
    end
    check(lows == 8, "R9 first out_valid edge", lows, 8);
    k = 0;
    while (k < 8) begin
      rdy = ($urandom_range(2, 0) != 0);
      out_ready = rdy;
      check(out_valid == 1'b1, "R10 out_valid during output", int'(out_valid), 1);
      check(in_ready == 1'b0, "R7 in_ready low while emitting", int'(in_ready), 0);
      held = out_row;
      held_last = out_last;
      if (rdy) begin
        check(out_last == (k == 7), "R10 out_last position", int'(out_last), int'(k == 7));
        for (int m = 0; m < 8; m++)
          check(w16(int'(out_row[m*16 +: 16])) == exp_c[k][m],
                $sformatf("%s coeff row %0d lane %0d", tag, k, m),
                w16(int'(out_row[m*16 +: 16])), exp_c[k][m]);
        k++;
      end
      @(posedge clk);
      @(negedge clk);
      if (!rdy) begin
        check(out_valid == 1'b1, "R8 valid held under stall", int'(out_valid), 1);
        check(out_row == held && out_last == held_last, "R8 row held under stall",
              int'(out_row[15:0]), int'(held[15:0]));
      end
    end
    out_ready = 0;
    check(in_ready == 1'b1, "R7 in_ready back after last row", int'(in_ready), 1);
    check(out_valid == 1'b0, "R7 out_valid low after last row", int'(out_valid), 0);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1; in_valid = 0; out_ready = 0; in_row = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    check(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
    check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    check(out_last == 1'b0, "R1 out_last after reset", int'(out_last), 0);

    // R1: abort a partly loaded tile
    in_valid = 1; in_row = {8{16'h1234}};
    repeat (3) @(negedge clk);
    rst = 1; in_valid = 0;
    repeat (2) @(negedge clk);
    rst = 0;
    check(in_ready == 1'b1 && out_valid == 1'b0, "R1 state after mid-tile reset",
          int'(in_ready), 1);
    for (int i = 0; i < 8; i++) for (int j = 0; j < 8; j++) blk[i][j] = i * 37 - j * 11;
    run_block("R1 tile after abort");

    // R3: impulse at every position
    for (int pos = 0; pos < 64; pos++) begin
      for (int i = 0; i < 8; i++) for (int j = 0; j < 8; j++) blk[i][j] = 0;
      blk[pos / 8][pos % 8] = (pos % 2) ? -1001 : 1000;
      run_block("R3 impulse");
    end
    // R3: pure vertical and horizontal ramps
    for (int i = 0; i < 8; i++) for (int j = 0; j < 8; j++) blk[i][j] = i * 150;
    run_block("R3 vertical ramp");
    for (int i = 0; i < 8; i++) for (int j = 0; j < 8; j++) blk[i][j] = j * 150;
    run_block("R3 horizontal ramp");

    // R2: pre-scale wrap
    for (int i = 0; i < 8; i++) for (int j = 0; j < 8; j++) blk[i][j] = 8192;
    run_block("R2 all 0x2000");
    for (int t = 0; t < 6; t++) begin
      for (int i = 0; i < 8; i++) for (int j = 0; j < 8; j++)
        blk[i][j] = w16(int'($urandom));
      run_block("R2 random beyond prescale range");
    end

    // R6: full-scale tiles
    for (int i = 0; i < 8; i++) for (int j = 0; j < 8; j++) blk[i][j] = 32767;
    run_block("R6 all max");
    for (int i = 0; i < 8; i++) for (int j = 0; j < 8; j++) blk[i][j] = -32768;
    run_block("R6 all min");
    for (int i = 0; i < 8; i++) for (int j = 0; j < 8; j++)
      blk[i][j] = ((i + j) % 2) ? -32768 : 32767;
    run_block("R6 checkerboard");
    for (int i = 0; i < 8; i++) for (int j = 0; j < 8; j++) blk[i][j] = (i < 4) ? 8191 : -8192;
    run_block("R6 half split");

    // R5: small tiles with many odd negative results
    for (int t = 0; t < 12; t++) begin
      for (int i = 0; i < 8; i++) for (int j = 0; j < 8; j++)
        blk[i][j] = int'($urandom_range(60, 0)) - 45;
      run_block("R5 small signed");
    end

    // R4: random tiles within the non-wrapping pre-scale range
    for (int t = 0; t < 20; t++) begin
      for (int i = 0; i < 8; i++) for (int j = 0; j < 8; j++)
        blk[i][j] = int'($urandom_range(16383, 0)) - 8192;
      run_block("R4 random");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule